// File: doc/BRIEF.md
# Logarithmic 8-bit Codec Unit

This unit converts between 20-bit unsigned magnitudes and compact 8-bit logarithmic symbols. A symbol holds a 4-bit exponent in its upper nibble and a 4-bit mantissa in its lower nibble. Each exponent band starts where the previous one ends, so the 256 symbols cover one gap-free range from 0 to 1,015,792. The spacing between neighbouring codes doubles with each band, which keeps the relative error at or below one sixteenth. This fits sensor readings, distances and back-off timers, where range matters more than exact precision.

A caller presents an operand with a valid strobe and a mode bit. In decode mode the low eight operand bits are read as a symbol and the 20-bit magnitude is returned. In encode mode the 20-bit operand is mapped to the symbol whose decoded magnitude is the largest one not above the operand. A leading-zero count picks the exponent. The result is registered and appears one clock after the strobe, together with a one-cycle valid pulse.

Top module: `log8_codec`

## Requirements
- R1: While reset is held and after its release, with no strobe given, `out_valid` is 0 and `out_result` is 0.
- R2: In decode mode (`in_mode` = 0) the symbol is `in_operand[7:0]`, with e = bits [7:4] and m = bits [3:0]. The result is m·2^e + 16·(2^e − 1), and `in_operand[19:8]` has no effect.
- R3: Decode gives 0x00→0, 0x01→1, 0x0F→15, 0x10→16, 0x1F→46, 0x20→48, 0x2F→108, 0x30→112, 0x3F→232, 0xF0→524272 and 0xFF→1015792.
- R4: In encode mode (`in_mode` = 1) with operand x ≤ 1015792, the result is the largest symbol whose decoded value does not exceed x. The exponent is the largest e with 16·(2^e − 1) ≤ x, and the mantissa is truncated toward zero.
- R5: In encode mode, any operand above 1015792 gives the symbol 0xFF.
- R6: An encode result sits in `out_result[7:0]`, and `out_result[19:8]` is 0.
- R7: `out_valid` is 1 in exactly the cycle after each clock edge at which `in_valid` was 1, and 0 otherwise.
- R8: While `in_valid` is 0, `out_result` keeps its last value, whatever `in_mode` and `in_operand` do.
- R9: For every symbol s, encoding the decoded value of s gives back s.
- R10: For any x ≤ 1015792 with y = decode(encode(x)) and e the exponent of encode(x), y ≤ x and x − y < 2^e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | 0 = decode symbol, 1 = encode magnitude |
| in_operand | input | 20 | Symbol in bits [7:0] for decode, magnitude for encode |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 20 | Decoded magnitude or zero-extended symbol |

## Verification
Fixed symbol/value pairs check the offset term of the decode formula, which a plain shift format would get wrong at every band start. Encode inputs are placed exactly on band starts, one below them, just under and over the top of the range, and in the middle of a wide band. These cases separate an off-by-one in the exponent choice from a rounding error in the mantissa, and show whether saturation works. A sweep over all 256 symbols tests decode against the formula, checks that encoding gives back each symbol, and checks that encoding one less gives the previous symbol. Values from a pseudo-random sequence then test the error bound, and directed pulses with the strobe low test latency and hold.

// File: rtl/log8_codec_pkg.sv
package log8_codec_pkg;

    localparam int DEF_VAL_W = 20;
    localparam int DEF_EXP_W = 4;
    localparam int DEF_MAN_W = 4;

    typedef enum logic {
        MODE_DECODE = 1'b0,
        MODE_ENCODE = 1'b1
    } codec_mode_e;

    // Largest magnitude a symbol can express: top mantissa in top band.
    function automatic longint top_value(input int exp_w, input int man_w);
        longint emax;
        emax = (longint'(1) << exp_w) - 1;
        return (((longint'(1) << man_w) - 1) << emax)
             + (((longint'(1) << emax) - 1) << man_w);
    endfunction

endpackage

// File: rtl/log8_lzc.sv
module log8_lzc #(
    parameter int W   = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/log8_decoder.sv
module log8_decoder #(
    parameter int VAL_W = log8_codec_pkg::DEF_VAL_W,
    parameter int EXP_W = log8_codec_pkg::DEF_EXP_W,
    parameter int MAN_W = log8_codec_pkg::DEF_MAN_W,
    localparam int SYM_W = EXP_W + MAN_W
) (
    input  logic [SYM_W-1:0] sym,
    output logic [VAL_W-1:0] value
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic [VAL_W-1:0] band_base;

    always_comb begin
        ex        = sym[SYM_W-1:MAN_W];
        mn        = sym[MAN_W-1:0];
        band_base = ((VAL_W'(1) << ex) - VAL_W'(1)) << MAN_W;
        value     = (VAL_W'(mn) << ex) + band_base;
    end
endmodule

// File: rtl/log8_encoder.sv
module log8_encoder #(
    parameter int VAL_W = log8_codec_pkg::DEF_VAL_W,
    parameter int EXP_W = log8_codec_pkg::DEF_EXP_W,
    parameter int MAN_W = log8_codec_pkg::DEF_MAN_W,
    localparam int SYM_W = EXP_W + MAN_W,
    localparam int TW    = VAL_W - MAN_W,
    localparam int CW    = $clog2(TW + 1),
    localparam int EMAX  = (1 << EXP_W) - 1,
    localparam logic [VAL_W-1:0] TOP =
        VAL_W'(log8_codec_pkg::top_value(EXP_W, MAN_W))
) (
    input  logic [VAL_W-1:0] value,
    output logic [SYM_W-1:0] sym
);
    logic [TW-1:0]    scaled;
    logic [CW-1:0]    zeros;
    logic [EXP_W-1:0] ex;
    logic [VAL_W-1:0] band_base;
    logic [MAN_W-1:0] mn;
    logic             over;

    // 16*(2^e-1) <= x  <=>  2^e <= (x>>4)+1, so e is the top set bit.
    assign scaled = value[VAL_W-1:MAN_W] + TW'(1);

    log8_lzc #(.W(TW)) u_lzc (
        .vec   (scaled),
        .zeros (zeros)
    );

    always_comb begin
        over      = value > TOP;
        ex        = EXP_W'(EMAX - int'(zeros));
        band_base = ((VAL_W'(1) << ex) - VAL_W'(1)) << MAN_W;
        mn        = MAN_W'((value - band_base) >> ex);
        sym       = over ? {SYM_W{1'b1}} : {ex, mn};
    end
endmodule

// File: rtl/log8_codec.sv
module log8_codec #(
    parameter int VAL_W = log8_codec_pkg::DEF_VAL_W,
    parameter int EXP_W = log8_codec_pkg::DEF_EXP_W,
    parameter int MAN_W = log8_codec_pkg::DEF_MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_mode,
    input  logic [VAL_W-1:0] in_operand,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_result
);
    import log8_codec_pkg::*;

    localparam int SYM_W = EXP_W + MAN_W;

    typedef struct packed {
        logic             valid;
        logic [VAL_W-1:0] result;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic [VAL_W-1:0] dec_value;
    logic [SYM_W-1:0] enc_sym;
    codec_mode_e      mode;

    assign mode = codec_mode_e'(in_mode);

    log8_decoder #(.VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
        .sym   (in_operand[SYM_W-1:0]),
        .value (dec_value)
    );

    log8_encoder #(.VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_enc (
        .value (in_operand),
        .sym   (enc_sym)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = (mode == MODE_ENCODE) ? VAL_W'(enc_sym) : dec_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
endmodule

// File: rtl/log8_codec_checker.sv
module log8_codec_checker #(
    parameter int VAL_W = log8_codec_pkg::DEF_VAL_W,
    parameter int EXP_W = log8_codec_pkg::DEF_EXP_W,
    parameter int MAN_W = log8_codec_pkg::DEF_MAN_W,
    localparam int SYM_W = EXP_W + MAN_W,
    localparam logic [VAL_W-1:0] TOP =
        VAL_W'(log8_codec_pkg::top_value(EXP_W, MAN_W))
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_mode,
    input logic [VAL_W-1:0] in_operand,
    input logic             out_valid,
    input logic [VAL_W-1:0] out_result
);
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    assert_enc_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode) |=> (out_result[VAL_W-1:SYM_W] == '0));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && (in_operand > TOP))
        |=> (out_result == VAL_W'({SYM_W{1'b1}})));

    assert_dec_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && (in_operand[SYM_W-1:0] == '0))
        |=> (out_result == '0));

    assert_dec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode) |=> (out_result <= TOP));
endmodule

bind log8_codec log8_codec_checker #(
    .VAL_W(VAL_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_log8_codec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/log8_codec_bench.sv
module log8_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [19:0] TOPV = 20'd1015792;

    typedef struct packed {
        logic        mode;
        logic [19:0] operand;
        logic [19:0] expect_val;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 20'h00000, 20'd0},
        '{1'b0, 20'h00001, 20'd1},
        '{1'b0, 20'h0000F, 20'd15},
        '{1'b0, 20'h00010, 20'd16},
        '{1'b0, 20'h0001F, 20'd46},
        '{1'b0, 20'h00020, 20'd48},
        '{1'b0, 20'h0002F, 20'd108},
        '{1'b0, 20'h00030, 20'd112},
        '{1'b0, 20'h0003F, 20'd232},
        '{1'b0, 20'h000F0, 20'd524272},
        '{1'b0, 20'h000FF, 20'd1015792},
        '{1'b0, 20'hABC10, 20'd16},
        '{1'b1, 20'd0,       20'h00},
        '{1'b1, 20'd15,      20'h0F},
        '{1'b1, 20'd16,      20'h10},
        '{1'b1, 20'd17,      20'h10},
        '{1'b1, 20'd47,      20'h1F},
        '{1'b1, 20'd48,      20'h20},
        '{1'b1, 20'd111,     20'h2F},
        '{1'b1, 20'd112,     20'h30},
        '{1'b1, 20'd233,     20'h3F},
        '{1'b1, 20'd524271,  20'hEF},
        '{1'b1, 20'd1015791, 20'hFE},
        '{1'b1, 20'd1015792, 20'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [19:0] in_operand = '0;
    logic        out_valid;
    logic [19:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    log8_codec u_log8_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [19:0] ref_dec(input logic [7:0] s);
        int e, m;
        e = int'(s[7:4]);
        m = int'(s[3:0]);
        return 20'(m * (1 << e) + 16 * ((1 << e) - 1));
    endfunction

    task automatic check(input string req, input logic [19:0] act,
                         input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic mode, input logic [19:0] x,
                          output logic [19:0] r);
        @(negedge clk);
        in_valid   = 1'b1;
        in_mode    = mode;
        in_operand = x;
        @(posedge clk);
        #1;
        r = out_result;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [19:0] r, r2, held, x;
        logic [19:0] lfsr;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", 20'(out_valid), 20'd0);
        check("R1 result in reset", out_result, 20'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 valid after reset", 20'(out_valid), 20'd0);
        check("R1 result after reset", out_result, 20'd0);

        // Table walk: R3 decode pairs (incl. R2 upper-bit ignore), R4 encode
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].mode, VECS[i].operand, r);
            check(VECS[i].mode ? "R4 encode vector" : "R3 decode vector",
                  r, VECS[i].expect_val);
        end

        // R5 saturation and R6 upper bits
        run_op(1'b1, TOPV + 20'd1, r);
        check("R5 just above top", r, 20'h0FF);
        run_op(1'b1, 20'hFFFFF, r);
        check("R5 all ones", r, 20'h0FF);
        run_op(1'b1, 20'd777777, r);
        check("R6 upper bits zero", {12'd0, r[19:8]}, 20'd0);

        // R7 latency and pulse width, R8 hold while idle
        @(negedge clk);
        in_valid = 1'b1; in_mode = 1'b0; in_operand = 20'h00030;
        @(posedge clk);
        #1;
        check("R7 valid one cycle after strobe", 20'(out_valid), 20'd1);
        check("R7 result with valid", out_result, 20'd112);
        @(negedge clk);
        in_valid = 1'b0; in_mode = 1'b1; in_operand = 20'd999999;
        held = out_result;
        @(posedge clk);
        #1;
        check("R7 valid drops", 20'(out_valid), 20'd0);
        check("R8 result held", out_result, held);
        @(negedge clk);
        in_mode = 1'b0; in_operand = 20'h000FF;
        @(posedge clk);
        #1;
        check("R8 result still held", out_result, held);
        check("R7 valid stays low", 20'(out_valid), 20'd0);

        // R2 formula and R9 round trip over all symbols, R4 step below
        for (int s = 0; s < 256; s++) begin
            run_op(1'b0, 20'(s), r);
            check("R2 decode formula", r, ref_dec(8'(s)));
            run_op(1'b1, ref_dec(8'(s)), r2);
            check("R9 encode of decode", r2, 20'(s));
            if (s > 0) begin
                run_op(1'b1, ref_dec(8'(s)) - 20'd1, r2);
                check("R4 one below code", r2, 20'(s - 1));
            end
        end

        // R10 error bound on pseudo-random magnitudes
        lfsr = 20'h5A5A5;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
            x = (lfsr > TOPV) ? (lfsr - TOPV) : lfsr;
            run_op(1'b1, x, r);
            run_op(1'b0, r, r2);
            check("R10 decoded not above input", 20'(r2 <= x), 20'd1);
            check("R10 error under step",
                  20'((x - r2) < (20'd1 << r[7:4])), 20'd1);
        end

        done = 1'b1;
        report();
    end
endmodule